// File: doc/BRIEF.md
# Triangle Raster Line Count Pipeline

This block sits at the front of a triangle set-up path. Each clock it can take one triangle, described by the vertical positions of its three vertices as IEEE single-precision values in the unit range (0.0 is the top screen edge, 1.0 the bottom) and by a 24-bit RGB colour for each vertex. Vertex A is the top vertex, B the lower-left and C the lower-right. For each triangle the block decides which of B and C lies lower on screen and computes how many raster lines lie between that vertex and A.

The span is found with a hand-written floating-point pipeline. An aligned subtract forms the vertical extent. A multiply by a parameterised single-precision scale, by default the 240-row screen height, replaces any divider. A float-to-integer step then truncates and clamps the result. Each arithmetic stage is one register deep, so a new triangle can enter every cycle and results leave in issue order after a fixed four-cycle latency. A valid flag, the choice of lower vertex and the nine colour bytes travel in a delay line beside the arithmetic and leave aligned with the line count. Only zero and positive normal operands are supported.

Top module: `tri_line_span`

## Requirements
- R1: The lower vertex is C when `in_cy`, read as an unsigned 32-bit integer, is greater than `in_by`; otherwise, including a tie, it is B. `out_sel` is 1 for C and 0 for B.
- R2: For a valid triangle, `out_lines` equals floor((lower.y - A.y) × scale), where the scale defaults to 240.0 (pattern 0x43700000).
- R3: When the lower vertex's y is less than or equal to `in_ay`, `out_lines` is 0.
- R4: `out_lines` never exceeds ROWS (default 240). A product above ROWS is reported as ROWS.
- R5: A triangle captured on rising edge k drives the outputs after rising edge k+3. One triangle per cycle is accepted, and results leave in issue order with no gaps.
- R6: `out_sel`, `out_a_rgb`, `out_b_rgb` and `out_c_rgb` leave on the same cycle as the line count of their own triangle. Colours are packed R in bits 23:16, G in 15:8 and B in 7:0.
- R7: A cycle with `in_valid` low produces a cycle with `out_valid` low four cycles later.
- R8: While `rst_n` is low, `out_valid` is 0. Triangles in flight when reset is asserted never appear on the outputs.
- R9: Spans below one line truncate to 0 and spans between one and two lines give 1. This holds when the two operands share an exponent and when their exponents differ widely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Triangle present on the inputs this cycle |
| in_ay | input | 32 | Top vertex y, single precision |
| in_by | input | 32 | Lower-left vertex y, single precision |
| in_cy | input | 32 | Lower-right vertex y, single precision |
| in_a_rgb | input | 24 | Top vertex colour |
| in_b_rgb | input | 24 | Lower-left vertex colour |
| in_c_rgb | input | 24 | Lower-right vertex colour |
| out_valid | output | 1 | Result present on the outputs this cycle |
| out_lines | output | 9 | Raster line count, truncated and clamped |
| out_sel | output | 1 | Lower vertex: 0 = B, 1 = C |
| out_a_rgb | output | 24 | Top vertex colour, delayed |
| out_b_rgb | output | 24 | Lower-left vertex colour, delayed |
| out_c_rgb | output | 24 | Lower-right vertex colour, delayed |

## Verification
The hardest situation to reach is a subtraction whose operands have equal or close exponents, leaving a small difference that must be renormalised by several places before the multiply. That path decides whether a sub-line span truncates to 0 or to 1. The stimulus table reaches it with exact dyadic values: a lower y just one 2^-7 step above a 0.25 top y, and spans of 2^-8 and 2^-7 from zero. The table is issued back to back, with a bubble, so that alignment across neighbouring triangles is exercised. A reset asserted while triangles are in flight covers the clearing of the delay line.

// File: rtl/tls_pkg.sv
package tls_pkg;

    // Unpacked positive float: hidden bit kept in mant[23]
    typedef struct packed {
        logic        zero;
        logic [7:0]  exp;
        logic [23:0] mant;
    } tls_fp_t;

    // Product with exponent overflow flag
    typedef struct packed {
        logic        zero;
        logic        big;
        logic [7:0]  exp;
        logic [23:0] mant;
    } tls_prod_t;

    // Operands after exponent alignment
    typedef struct packed {
        logic        zero;
        logic [7:0]  ex;
        logic [23:0] mx;
        logic [23:0] ma;
    } tls_align_t;

    function automatic logic [4:0] tls_lzc24(input logic [23:0] v);
        logic [4:0] n;
        logic       found;
        n     = 5'd24;
        found = 1'b0;
        for (int i = 23; i >= 0; i--) begin
            if (!found && v[i]) begin
                n     = 5'(23 - i);
                found = 1'b1;
            end
        end
        return n;
    endfunction

endpackage

// File: rtl/tls_span_sub.sv
module tls_span_sub
    import tls_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] y_top,
    input  logic [31:0] y_bot,
    output tls_fp_t     diff_q
);

    tls_align_t al_d, al_q;
    tls_fp_t    diff_d;

    // Stage 1: compare and align the smaller operand
    always_comb begin
        logic [7:0]  ea;
        logic [7:0]  sh;
        logic [23:0] ma_full;
        al_d      = '0;
        ea        = y_top[30:23];
        al_d.ex   = y_bot[30:23];
        al_d.mx   = {(y_bot[30:23] != 8'd0), y_bot[22:0]};
        ma_full   = {(ea != 8'd0), y_top[22:0]};
        sh        = al_d.ex - ea;
        al_d.ma   = ma_full >> sh;
        al_d.zero = !(y_bot > y_top);
    end

    // Stage 2: subtract and renormalise
    always_comb begin
        logic [23:0] d;
        logic [4:0]  lz;
        diff_d      = '0;
        d           = al_q.mx - al_q.ma;
        lz          = tls_lzc24(d);
        diff_d.exp  = al_q.ex - {3'b000, lz};
        diff_d.mant = d << lz;
        diff_d.zero = al_q.zero || (d == 24'd0) || ({3'b000, lz} >= al_q.ex);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            al_q   <= '0;
            diff_q <= '0;
        end else begin
            al_q   <= al_d;
            diff_q <= diff_d;
        end
    end

endmodule

// File: rtl/tls_span_mul.sv
module tls_span_mul
    import tls_pkg::*;
#(
    parameter logic [31:0] SCALE = 32'h43700000
) (
    input  logic      clk,
    input  logic      rst_n,
    input  tls_fp_t   a,
    output tls_prod_t p_q
);

    localparam logic [7:0]  C_EXP  = SCALE[30:23];
    localparam logic [23:0] C_MANT = {1'b1, SCALE[22:0]};
    localparam logic        C_OFF  = SCALE[31] || (SCALE[30:23] == 8'd0);
    localparam int          BIAS   = 127;

    tls_prod_t p_d;

    always_comb begin
        logic [47:0] prod;
        logic [23:0] m24;
        logic [24:0] m25;
        logic        guard;
        logic        sticky;
        int          e;
        p_d  = '0;
        prod = 48'(a.mant) * 48'(C_MANT);
        if (prod[47]) begin
            m24    = prod[47:24];
            guard  = prod[23];
            sticky = |prod[22:0];
            e      = int'(a.exp) + int'(C_EXP) - BIAS + 1;
        end else begin
            m24    = prod[46:23];
            guard  = prod[22];
            sticky = |prod[21:0];
            e      = int'(a.exp) + int'(C_EXP) - BIAS;
        end
        // round to nearest, ties to even
        m25 = {1'b0, m24} + {24'd0, guard && (sticky || m24[0])};
        if (m25[24]) begin
            p_d.mant = m25[24:1];
            e        = e + 1;
        end else begin
            p_d.mant = m25[23:0];
        end
        p_d.zero = a.zero || C_OFF || (e <= 0);
        p_d.big  = (e >= 255);
        p_d.exp  = 8'(e);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

endmodule

// File: rtl/tls_span_int.sv
module tls_span_int
    import tls_pkg::*;
#(
    parameter int ROWS  = 240,
    parameter int CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tls_prod_t        p,
    output logic [CNT_W-1:0] lines_q
);

    localparam int BIAS = 127;
    localparam int LIM  = BIAS + CNT_W;
    localparam int FRAC = 23;

    logic [CNT_W-1:0] lines_d;

    always_comb begin
        logic [23:0] v;
        int          sh;
        sh      = BIAS + FRAC - int'(p.exp);
        v       = p.mant >> sh;
        lines_d = '0;
        if (p.zero) begin
            lines_d = '0;
        end else if (p.big || int'(p.exp) >= LIM) begin
            lines_d = CNT_W'(ROWS);
        end else if (int'(p.exp) < BIAS) begin
            lines_d = '0;
        end else if (v > 24'(ROWS)) begin
            lines_d = CNT_W'(ROWS);
        end else begin
            lines_d = v[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lines_q <= '0;
        else        lines_q <= lines_d;
    end

endmodule

// File: rtl/tls_pipe_delay.sv
module tls_pipe_delay #(
    parameter int W     = 73,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);

    logic [DEPTH-1:0] vld_q;
    logic [W-1:0]     dat_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
        logic         vld_d;
        logic [W-1:0] dat_d;
        if (g == 0) begin : g_head
            always_comb begin
                vld_d = in_valid;
                dat_d = in_data;
            end
        end else begin : g_body
            always_comb begin
                vld_d = vld_q[g-1];
                dat_d = dat_q[g-1];
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) vld_q[g] <= 1'b0;
            else        vld_q[g] <= vld_d;
        end
        always_ff @(posedge clk) begin
            dat_q[g] <= dat_d;
        end
    end

    assign out_valid = vld_q[DEPTH-1];
    assign out_data  = dat_q[DEPTH-1];

endmodule

// File: rtl/tri_line_span.sv
module tri_line_span
    import tls_pkg::*;
#(
    parameter logic [31:0] SCALE = 32'h43700000,
    parameter int          ROWS  = 240,
    parameter int          CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [31:0]      in_ay,
    input  logic [31:0]      in_by,
    input  logic [31:0]      in_cy,
    input  logic [23:0]      in_a_rgb,
    input  logic [23:0]      in_b_rgb,
    input  logic [23:0]      in_c_rgb,
    output logic             out_valid,
    output logic [CNT_W-1:0] out_lines,
    output logic             out_sel,
    output logic [23:0]      out_a_rgb,
    output logic [23:0]      out_b_rgb,
    output logic [23:0]      out_c_rgb
);

    localparam int LAT    = 4;
    localparam int SIDE_W = 1 + 3 * 24;

    logic              pick_c;
    logic [31:0]       y_low;
    logic [SIDE_W-1:0] side_in;
    logic [SIDE_W-1:0] side_out;
    tls_fp_t           diff_q;
    tls_prod_t         prod_q;

    always_comb begin
        pick_c  = (in_cy > in_by);
        y_low   = pick_c ? in_cy : in_by;
        side_in = {pick_c, in_a_rgb, in_b_rgb, in_c_rgb};
    end

    tls_span_sub u_sub (
        .clk    (clk),
        .rst_n  (rst_n),
        .y_top  (in_ay),
        .y_bot  (y_low),
        .diff_q (diff_q)
    );

    tls_span_mul #(.SCALE(SCALE)) u_mul (
        .clk   (clk),
        .rst_n (rst_n),
        .a     (diff_q),
        .p_q   (prod_q)
    );

    tls_span_int #(.ROWS(ROWS), .CNT_W(CNT_W)) u_int (
        .clk     (clk),
        .rst_n   (rst_n),
        .p       (prod_q),
        .lines_q (out_lines)
    );

    tls_pipe_delay #(.W(SIDE_W), .DEPTH(LAT)) u_side (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (side_in),
        .out_valid (out_valid),
        .out_data  (side_out)
    );

    assign out_sel   = side_out[SIDE_W-1];
    assign out_a_rgb = side_out[71:48];
    assign out_b_rgb = side_out[47:24];
    assign out_c_rgb = side_out[23:0];

endmodule

// File: rtl/tri_line_span_chk.sv
module tri_line_span_chk #(
    parameter int ROWS  = 240,
    parameter int CNT_W = 9
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [31:0]      in_ay,
    input logic [31:0]      in_by,
    input logic [31:0]      in_cy,
    input logic [23:0]      in_a_rgb,
    input logic [23:0]      in_b_rgb,
    input logic [23:0]      in_c_rgb,
    input logic             out_valid,
    input logic [CNT_W-1:0] out_lines,
    input logic             out_sel,
    input logic [23:0]      out_a_rgb,
    input logic [23:0]      out_b_rgb,
    input logic [23:0]      out_c_rgb
);

    logic [2:0]  cyc_q;
    logic        warm;
    logic [31:0] low_y;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cyc_q <= 3'd0;
        else if (cyc_q < 3'd4)  cyc_q <= cyc_q + 3'd1;
    end

    assign warm  = (cyc_q >= 3'd4);
    assign low_y = (in_cy > in_by) ? in_cy : in_by;

    AST_LINES_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (32'(out_lines) <= 32'(ROWS)));  // R4

    AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        warm |-> (out_valid == $past(in_valid, 4)));  // R5 R7

    AST_SEL_PICK: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |-> (out_sel == ($past(in_cy, 4) > $past(in_by, 4))));  // R1

    AST_COLOUR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid) |->
        ({out_a_rgb, out_b_rgb, out_c_rgb} == $past({in_a_rgb, in_b_rgb, in_c_rgb}, 4)));  // R6

    AST_ZERO_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (warm && out_valid && ($past(low_y, 4) <= $past(in_ay, 4))) |-> (out_lines == '0));  // R3

    AST_RESET_CLEAR: assert property (@(posedge clk)
        !rst_n |-> !out_valid);  // R8

endmodule

bind tri_line_span tri_line_span_chk #(.ROWS(ROWS), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ay     (in_ay),
    .in_by     (in_by),
    .in_cy     (in_cy),
    .in_a_rgb  (in_a_rgb),
    .in_b_rgb  (in_b_rgb),
    .in_c_rgb  (in_c_rgb),
    .out_valid (out_valid),
    .out_lines (out_lines),
    .out_sel   (out_sel),
    .out_a_rgb (out_a_rgb),
    .out_b_rgb (out_b_rgb),
    .out_c_rgb (out_c_rgb)
);

// File: tb/tri_line_span_tb.sv
module tri_line_span_tb;

    typedef struct packed {
        logic        v;
        logic [31:0] ay;
        logic [31:0] by;
        logic [31:0] cy;
        logic [8:0]  lines;
        logic        sel;
    } vec_t;

    localparam int N = 12;

    // y patterns: 0.0=0, 2^-8=3B800000, 2^-7=3C000000, 0.125=3E000000,
    // 0.25=3E800000, 0.25+2^-7=3E840000, 0.375=3EC00000, 0.5=3F000000,
    // 0.625=3F200000, 0.75=3F400000, 0.875=3F600000, 1.0=3F800000, 1.5=3FC00000
    localparam vec_t VEC [N] = '{
        '{1'b1, 32'h3E800000, 32'h3F800000, 32'h3F000000, 9'd180, 1'b0}, // R2 B lower
        '{1'b1, 32'h3E000000, 32'h3F000000, 32'h3F600000, 9'd180, 1'b1}, // R1 C lower
        '{1'b1, 32'h3F000000, 32'h3F200000, 32'h3F200000, 9'd30,  1'b0}, // R1 tie -> B
        '{1'b1, 32'h00000000, 32'h3F800000, 32'h3F400000, 9'd240, 1'b0}, // R2 full height
        '{1'b1, 32'h3F000000, 32'h3E800000, 32'h3F000000, 9'd0,   1'b1}, // R3 equal
        '{1'b1, 32'h3F400000, 32'h3E800000, 32'h3E000000, 9'd0,   1'b0}, // R3 above top
        '{1'b1, 32'h00000000, 32'h3B800000, 32'h00000000, 9'd0,   1'b0}, // R9 0.9375
        '{1'b1, 32'h00000000, 32'h00000000, 32'h3C000000, 9'd1,   1'b1}, // R9 1.875
        '{1'b1, 32'h3E800000, 32'h00000000, 32'h3E840000, 9'd1,   1'b1}, // R9 same exp
        '{1'b1, 32'h00000000, 32'h3FC00000, 32'h3E800000, 9'd240, 1'b0}, // R4 clamp 360
        '{1'b0, 32'h3E800000, 32'h3F800000, 32'h3F000000, 9'd0,   1'b0}, // R7 bubble
        '{1'b1, 32'h3E800000, 32'h3EC00000, 32'h3E000000, 9'd30,  1'b0}  // R2 after bubble
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_ay = '0, in_by = '0, in_cy = '0;
    logic [23:0] in_a_rgb = '0, in_b_rgb = '0, in_c_rgb = '0;
    logic        out_valid;
    logic [8:0]  out_lines;
    logic        out_sel;
    logic [23:0] out_a_rgb, out_b_rgb, out_c_rgb;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    tri_line_span u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_ay     (in_ay),
        .in_by     (in_by),
        .in_cy     (in_cy),
        .in_a_rgb  (in_a_rgb),
        .in_b_rgb  (in_b_rgb),
        .in_c_rgb  (in_c_rgb),
        .out_valid (out_valid),
        .out_lines (out_lines),
        .out_sel   (out_sel),
        .out_a_rgb (out_a_rgb),
        .out_b_rgb (out_b_rgb),
        .out_c_rgb (out_c_rgb)
    );

    function automatic logic [71:0] colours(input int i);
        logic [23:0] a;
        a = {8'(i * 37 + 3), 8'(i * 11 + 90), 8'(i * 5 + 200)};
        return {a, ~a, {a[7:0], a[23:8]}};
    endfunction

    task automatic check(input string tag, input logic [79:0] act, input logic [79:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input int i);
        logic [71:0] c;
        c        = colours(i);
        in_valid = VEC[i].v;
        in_ay    = VEC[i].ay;
        in_by    = VEC[i].by;
        in_cy    = VEC[i].cy;
        in_a_rgb = c[71:48];
        in_b_rgb = c[47:24];
        in_c_rgb = c[23:0];
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R8 valid low in reset", 80'(out_valid), 80'd0);
        rst_n = 1'b1;

        // table, issued back to back
        for (int c = 0; c < N + 4; c++) begin
            @(negedge clk);
            if (c >= 4) begin
                int k;
                k = c - 4;
                check("R5 R7 valid slot", 80'(out_valid), 80'(VEC[k].v));
                if (VEC[k].v) begin
                    check("R2 R3 R4 R9 lines", 80'(out_lines), 80'(VEC[k].lines));
                    check("R1 sel", 80'(out_sel), 80'(VEC[k].sel));
                    check("R6 colours", 80'({out_a_rgb, out_b_rgb, out_c_rgb}), 80'(colours(k)));
                end
            end else begin
                check("R8 idle after reset", 80'(out_valid), 80'd0);
            end
            if (c < N) drive(c);
            else       in_valid = 1'b0;
        end

        // reset with triangles in flight
        @(negedge clk); drive(0);
        @(negedge clk); drive(1);
        @(negedge clk); in_valid = 1'b0; rst_n = 1'b0;
        #1;
        check("R8 cleared in reset", 80'(out_valid), 80'd0);
        @(negedge clk); rst_n = 1'b1;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            check("R8 in-flight dropped", 80'(out_valid), 80'd0);
        end

        // isolated triangle latency
        @(negedge clk); drive(3);
        @(negedge clk); in_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check("R5 not early", 80'(out_valid), 80'd0);
        @(negedge clk);
        check("R5 arrives", 80'(out_valid), 80'd1);
        check("R5 R2 lines", 80'(out_lines), 80'd240);
        @(negedge clk);
        check("R5 single result", 80'(out_valid), 80'd0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule